// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block is a periodic interrupt timer built around a 16-bit down-counter. The counter is advanced by a slow time base, which reaches the block as a single-cycle enable (`slow_tick_i`) in the register clock domain. A 5-bit prescaler divides that enable before it reaches the counter. Software sets the divide value, the start value, the reload mode and the interrupt enable through a small write/read register port, and then issues a start command.

When the count expires, a sticky terminal-count flag is set. If the interrupt is enabled, the flag also drives the interrupt output. The counter then either reloads the start value and keeps running, or it stops at zero. A lock bit freezes the configuration registers until the next reset. A debug freeze input holds both the prescaler and the counter. In test mode, the live count can be read back.

Register map (3-bit address, 16-bit data):

| Address | Register | Contents |
|---|---|---|
| 0 | CTRL | bit0 reload mode, bit1 interrupt enable, bit2 lock |
| 1 | PRESET | 16-bit start value |
| 2 | PSC | prescale value in bits 4:0 |
| 3 | CMD | write-only: bit0 start, bit1 stop |
| 4 | STATUS | bit0 terminal-count flag (write 1 to clear), bit1 running |
| 5 | COUNT | live count, read only |

Top module: `periodic_timer`

## Requirements
- R1: After reset, CTRL (addr 0), PRESET (addr 1), PSC (addr 2), STATUS (addr 4) and COUNT (addr 5) all read 0. `irq_o` is 0 and the timer is not running.
- R2: The prescaler forwards one counter tick per (PSC+1) asserted `slow_tick_i` cycles. After a start command (CMD bit0), the terminal flag (STATUS bit0) becomes visible after exactly max(PRESET,1)×(PSC+1) slow ticks.
- R3: The terminal flag is sticky and is cleared by writing 1 to STATUS bit0. If a clear and a terminal event fall in the same cycle, the flag stays set.
- R4: `irq_o` equals the terminal flag ANDed with the interrupt enable (CTRL bit1).
- R5: With reload mode set (CTRL bit0 = 1), each expiry reloads PRESET and counting continues with the same period.
- R6: With reload mode clear, expiry stops the timer. STATUS bit1 reads 0, COUNT reads 0, and further slow ticks set no new flag.
- R7: A PRESET write while the timer runs does not change the count in progress. It takes effect at the next reload or start.
- R8: Once CTRL bit2 (lock) is written to 1, writes to CTRL, PRESET and PSC are ignored until reset. After a reset, writes work again.
- R9: While `freeze_i` is high, neither the prescaler nor the counter advances. Counting resumes from the held state when it is released.
- R10: COUNT reads the live count only while `test_mode_i` is high; otherwise it reads 0.
- R11: A start command while running restarts from PRESET with the prescaler cleared.
- R12: A PRESET of 0 behaves as 1, so the timer expires on every counter tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | Slow time base enable, one cycle per slow period |
| freeze_i | input | 1 | Debug freeze, holds prescaler and counter |
| test_mode_i | input | 1 | Enables count readback |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes are captured on the rising edge where `we_i` is high, and their effect is readable from the next falling edge. Reads are combinational. The terminal flag sets on the same rising edge that consumes the slow tick that expires the count, so it is visible at the falling edge that follows. The bench drives stimuli and samples `rdata_o` and `irq_o` only at falling edges. While waiting for expiry, it counts the slow ticks it has issued and compares that count with max(PRESET,1)×(PSC+1) when the flag first reads set.

// File: rtl/periodic_timer_pkg.sv
package periodic_timer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_PRESET = 3'd1,
    REG_PSC    = 3'd2,
    REG_CMD    = 3'd3,
    REG_STAT   = 3'd4,
    REG_COUNT  = 3'd5
  } reg_addr_e;

  localparam int CTRL_RELOAD = 0;
  localparam int CTRL_IRQ_EN = 1;
  localparam int CTRL_LOCK   = 2;
  localparam int CMD_START   = 0;
  localparam int CMD_STOP    = 1;
  localparam int STAT_TC     = 0;
  localparam int STAT_RUN    = 1;
endpackage

// File: rtl/periodic_timer_regs.sv
module periodic_timer_regs
  import periodic_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  preset_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic              reload_o,
  output logic              irq_en_o,
  output logic              locked_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              clr_tc_o
);
  logic wr_ctrl, wr_preset, wr_psc;
  logic [CNT_W-1:0] preset_q;
  logic [PSC_W-1:0] psc_q;
  logic reload_q, irq_en_q, lock_q;

  assign wr_ctrl   = we_i && (addr_i == REG_CTRL)   && !lock_q;
  assign wr_preset = we_i && (addr_i == REG_PRESET) && !lock_q;
  assign wr_psc    = we_i && (addr_i == REG_PSC)    && !lock_q;
  assign start_o   = we_i && (addr_i == REG_CMD)  && wdata_i[CMD_START];
  assign stop_o    = we_i && (addr_i == REG_CMD)  && wdata_i[CMD_STOP];
  assign clr_tc_o  = we_i && (addr_i == REG_STAT) && wdata_i[STAT_TC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      preset_q <= '0;
      psc_q    <= '0;
      reload_q <= 1'b0;
      irq_en_q <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        reload_q <= wdata_i[CTRL_RELOAD];
        irq_en_q <= wdata_i[CTRL_IRQ_EN];
        lock_q   <= wdata_i[CTRL_LOCK];
      end
      if (wr_preset) preset_q <= wdata_i;
      if (wr_psc)    psc_q    <= wdata_i[PSC_W-1:0];
    end
  end

  assign preset_o = preset_q;
  assign psc_o    = psc_q;
  assign reload_o = reload_q;
  assign irq_en_o = irq_en_q;
  assign locked_o = lock_q;

  // R8
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  // R8
  locked_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && we_i && addr_i == REG_PRESET) |=> $stable(preset_q));
  // R8
  locked_psc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && we_i && addr_i == REG_PSC) |=> $stable(psc_q));
endmodule

// File: rtl/periodic_timer_prescaler.sv
module periodic_timer_prescaler #(
  parameter int PSC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clear_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] pcnt_q;

  // >= so a smaller divide written mid-run cannot overrun
  assign tick_o = en_i && !clear_i && (pcnt_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pcnt_q <= '0;
    else if (clear_i)  pcnt_q <= '0;
    else if (en_i)     pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clear_i) |=> $stable(pcnt_q));
  // R2
  wrap_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (pcnt_q == '0));
endmodule

// File: rtl/periodic_timer_counter.sv
module periodic_timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic             clr_tc_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             tc_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic running_q, tc_q, at_end, step, terminal;

  assign at_end   = (cnt_q == '0) || (cnt_q == ONE);
  assign step     = running_q && tick_i && !start_i && !stop_i;
  assign terminal = step && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else if (start_i) begin
      cnt_q     <= preset_i;
      running_q <= 1'b1;
    end else if (stop_i) begin
      running_q <= 1'b0;
    end else if (step) begin
      if (at_end) begin
        if (reload_i) begin
          cnt_q <= preset_i;
        end else begin
          cnt_q     <= '0;
          running_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tc_q <= 1'b0;
    else if (terminal)  tc_q <= 1'b1;
    else if (clr_tc_i)  tc_q <= 1'b0;
  end

  assign cnt_o     = cnt_q;
  assign running_o = running_q;
  assign tc_o      = tc_q;

  // R2
  decrement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !at_end) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R3
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    terminal |=> tc_q);
  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (terminal && reload_i) |=> (running_q && cnt_q == $past(preset_i)));
  // R6
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (terminal && !reload_i) |=> (!running_q && cnt_q == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/periodic_timer.sv
module periodic_timer
  import periodic_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              freeze_i,
  input  logic              test_mode_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] preset, cnt;
  logic [PSC_W-1:0] psc;
  logic reload, irq_en, locked, start, stop, clr_tc;
  logic running, tc, psc_en, tick;

  periodic_timer_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .preset_o(preset), .psc_o(psc), .reload_o(reload), .irq_en_o(irq_en),
    .locked_o(locked), .start_o(start), .stop_o(stop), .clr_tc_o(clr_tc)
  );

  assign psc_en = running && !freeze_i && slow_tick_i;

  periodic_timer_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_ni, .en_i(psc_en), .clear_i(start), .psc_i(psc), .tick_o(tick)
  );

  periodic_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop), .tick_i(tick),
    .reload_i(reload), .clr_tc_i(clr_tc), .preset_i(preset),
    .cnt_o(cnt), .running_o(running), .tc_o(tc)
  );

  assign irq_o = tc && irq_en;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[CTRL_RELOAD] = reload;
        rdata_o[CTRL_IRQ_EN] = irq_en;
        rdata_o[CTRL_LOCK]   = locked;
      end
      REG_PRESET: rdata_o = preset;
      REG_PSC:    rdata_o[PSC_W-1:0] = psc;
      REG_STAT: begin
        rdata_o[STAT_TC]  = tc;
        rdata_o[STAT_RUN] = running;
      end
      REG_COUNT:  rdata_o = test_mode_i ? cnt : '0;
      default:    rdata_o = '0;
    endcase
  end

  // R4
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en && tc));
  // R9
  frozen_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |-> !tick);
  // R9
  frozen_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !start) |=> $stable(cnt));
endmodule

// File: tb/periodic_timer_bench.sv
module periodic_timer_bench;
  import periodic_timer_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slow = 1'b0, frz = 1'b0, tmode = 1'b1, we = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  wire [15:0] rdata;
  wire irq;
  int checks = 0, errors = 0, cyc = 0;

  periodic_timer u_periodic_timer (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow), .freeze_i(frz),
    .test_mode_i(tmode), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  // counts slow ticks issued until STATUS bit0 reads set
  task automatic measure(int gap, output int k);
    int c = 0;
    k = 0; slow = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk); addr = REG_STAT; #1;
      if (rdata[STAT_TC]) break;
      slow = ((c % (gap + 1)) == 0);
      c++;
      if (slow) k++;
    end
    slow = 1'b0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow = 1'b1;
    end
    @(negedge clk); slow = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  int v, k, e;
  int p_list[5] = '{0, 1, 2, 5, 31};
  int n_list[4] = '{0, 1, 2, 7};

  initial begin
    do_reset();
    // R1
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R1 reset read", v, 0);
    end
    check("R1 irq", int'(irq), 0);

    // R2 R5 R12 sweep in reload mode
    foreach (p_list[pi]) foreach (n_list[ni]) for (int g = 0; g < 3; g += 2) begin
      e = ((n_list[ni] == 0) ? 1 : n_list[ni]) * (p_list[pi] + 1);
      wr(REG_CTRL, 16'h1);
      wr(REG_PSC, 16'(p_list[pi]));
      wr(REG_PRESET, 16'(n_list[ni]));
      wr(REG_CMD, 16'h1);
      measure(g, k);
      check(n_list[ni] == 0 ? "R12 zero preset" : "R2 first period", k, e);
      wr(REG_STAT, 16'h1);
      rd(REG_STAT, v); check("R3 w1c clears flag", v & 1, 0);
      measure(g, k);
      check("R5 reload period", k, e);
      wr(REG_CMD, 16'h2);
      wr(REG_STAT, 16'h1);
    end

    // R6 one-shot
    wr(REG_CTRL, 16'h0); wr(REG_PSC, 16'd1); wr(REG_PRESET, 16'd3);
    wr(REG_CMD, 16'h1);
    measure(0, k); check("R6 one-shot period", k, 6);
    rd(REG_STAT, v); check("R6 stopped", (v >> 1) & 1, 0);
    rd(REG_COUNT, v); check("R6 count zero", v, 0);
    wr(REG_STAT, 16'h1);
    pulses(10);
    rd(REG_STAT, v); check("R6 no new flag", v & 1, 0);

    // R4 interrupt gating
    wr(REG_PSC, 16'd0); wr(REG_PRESET, 16'd1); wr(REG_CMD, 16'h1);
    measure(0, k);
    #1 check("R4 irq masked", int'(irq), 0);
    wr(REG_CTRL, 16'h2);
    #1 check("R4 irq enabled", int'(irq), 1);
    wr(REG_STAT, 16'h1);
    #1 check("R4 irq after clear", int'(irq), 0);

    // R3 set wins over clear
    wr(REG_CTRL, 16'h1); wr(REG_CMD, 16'h1);
    @(negedge clk); we = 1'b1; addr = REG_STAT; wdata = 16'h1; slow = 1'b1;
    @(negedge clk); we = 1'b0; slow = 1'b0;
    rd(REG_STAT, v); check("R3 set wins", v & 1, 1);
    wr(REG_CMD, 16'h2); wr(REG_STAT, 16'h1);

    // R7 preset change mid-run
    wr(REG_PRESET, 16'd4); wr(REG_CMD, 16'h1);
    pulses(1);
    wr(REG_PRESET, 16'd2);
    measure(0, k); check("R7 current run kept", k, 3);
    wr(REG_STAT, 16'h1);
    measure(0, k); check("R7 new preset at reload", k, 2);
    wr(REG_STAT, 16'h1);

    // R11 restart
    wr(REG_PSC, 16'd1); wr(REG_PRESET, 16'd5); wr(REG_CMD, 16'h1);
    pulses(5);
    wr(REG_CMD, 16'h1);
    measure(0, k); check("R11 restart full period", k, 10);
    wr(REG_STAT, 16'h1);

    // R9 freeze
    wr(REG_PRESET, 16'd3); wr(REG_CMD, 16'h1);
    pulses(1);
    frz = 1'b1;
    pulses(10);
    rd(REG_COUNT, v); check("R9 count held", v, 3);
    rd(REG_STAT, v); check("R9 no flag", v & 1, 0);
    frz = 1'b0;
    measure(0, k); check("R9 resume remainder", k, 5);
    wr(REG_STAT, 16'h1);

    // R10 test-mode readback (count reloaded to 3)
    tmode = 1'b0;
    rd(REG_COUNT, v); check("R10 hidden", v, 0);
    tmode = 1'b1;
    rd(REG_COUNT, v); check("R10 visible", v, 3);

    // R8 lock
    wr(REG_CTRL, 16'h5);
    wr(REG_PRESET, 16'd9); wr(REG_PSC, 16'd7); wr(REG_CTRL, 16'h2);
    rd(REG_CTRL, v);   check("R8 ctrl locked", v, 5);
    rd(REG_PRESET, v); check("R8 preset locked", v, 3);
    rd(REG_PSC, v);    check("R8 psc locked", v, 1);
    do_reset();
    rd(REG_CTRL, v); check("R1 ctrl after reset", v, 0);
    wr(REG_PRESET, 16'd9);
    rd(REG_PRESET, v); check("R8 unlocked by reset", v, 9);

    summary();
    $finish;
  end
endmodule